// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencing Controller

This block coordinates transfers between a working SRAM array and the nonvolatile shadow copy behind it. A store copies the array into the shadow. A recall first wipes the array and then reloads it from the shadow, and it never changes the shadow itself. A store can be requested on a shared active-low busy/request pin or by a software strobe. A recall starts automatically when the supply-good signal rises, and it can also be requested by a software strobe.

The controller keeps a dirty latch so that a store runs only when the array has been written since the last transfer. On a pin request it waits out a grace window, so that a write already under way can finish. It gates the host's read and write enables, and it drives the busy pin through separate controls for pull-low, a brief drive-high pulse and release. After each store, accesses stay locked for a further lockout period. All timing is counted in clock cycles and set by parameters.

The bus-side pin value is `pin_in`. The device drives it low when `busy_drive_low` is set, drives it high when `busy_drive_high` is set, and otherwise releases it to the external driver, with a weak pull-up to high.

Top module: `nv_shadow_seq`

## Requirements
- R1: When `pin_in` is seen low while the block is idle and not driving the pin, the block waits exactly DELAY_CYC cycles, then starts a store if the dirty latch is set.
- R2: An accepted write (`wr_en`=1) sets the dirty latch, and a completed store or recall clears it. A software store strobe that arrives while the latch is clear has no effect, and the busy pin stays undriven.
- R3: If a write was granted in the cycle before the pin request and `wr_req` stays high, that write keeps `wr_en` during the delay window. A write request that starts after the pin went low is refused until the pin is high again.
- R4: A pin request that arrives with a clean latch never asserts `busy_drive_low`. Reads and writes stay blocked until `pin_in` returns high, and `rd_en` follows `rd_req` again in the first cycle after release.
- R5: Every store holds `store_req` and `busy_drive_low` high for exactly STORE_CYC cycles, with no read or write granted during that time.
- R6: Every store is followed by exactly PULSE_CYC cycles of `busy_drive_high`, and the pin is then released. `busy_drive_high` and `busy_drive_low` are never high together.
- R7: After the drive-high pulse, reads and writes stay blocked for exactly LOCK_CYC further cycles.
- R8: A rising `pwr_good`, or a `sw_recall` strobe while idle, runs a recall that holds `busy_drive_low` for exactly RECALL_CYC cycles. No drive-high pulse follows a recall.
- R9: A recall issues one `recall_clear` strobe in its first cycle and one `recall_load` strobe in its last cycle. `store_req` stays low throughout.
- R10: While `pwr_good` is low, no read or write is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply above threshold |
| pin_in | input | 1 | Resolved level of the shared busy/request pin |
| sw_store | input | 1 | Software store strobe |
| sw_recall | input | 1 | Software recall strobe |
| rd_req | input | 1 | Host read request |
| wr_req | input | 1 | Host write request |
| rd_en | output | 1 | Read granted to the array |
| wr_en | output | 1 | Write granted to the array |
| busy_drive_low | output | 1 | Pull the busy pin low |
| busy_drive_high | output | 1 | Drive the busy pin high |
| store_req | output | 1 | Store in progress, toward the array model |
| recall_clear | output | 1 | Recall step one: wipe the array |
| recall_load | output | 1 | Recall step two: load the array from the shadow |

## Verification
The assertions check the relations that must hold in every cycle. The two pin drives never overlap, and no access is granted while the pin is pulled low or while supply is absent. Each store's end is followed by the drive-high pulse, the first cycle after that pulse is locked, and the recall strobes fall inside the busy period. The exact lengths of the delay, store, pulse, lockout and recall windows, and the effect of the dirty latch, can only be shown by the bench's scenarios. So can the handling of in-flight and late writes, and the release of a clean pin request.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HWDLY,
      ST_HOLD,
      ST_STORE,
      ST_PULSE,
      ST_LOCK,
      ST_RECALL
   } nvs_state_e;
endpackage

// File: rtl/nvs_dirty_latch.sv
module nvs_dirty_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic dirty_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dirty_o <= 1'b0;
      else if (clr_i) dirty_o <= 1'b0;
      else if (set_i) dirty_o <= 1'b1;
   end
endmodule

// File: rtl/nvs_access_gate.sv
module nvs_access_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,      // accesses freely allowed
   input  logic grace_i,     // in-flight writes may continue
   input  logic rd_req,
   input  logic wr_req,
   output logic rd_en,
   output logic wr_en
);
   logic inflight_q;

   assign rd_en = rd_req && open_i;
   assign wr_en = wr_req && (open_i || (grace_i && inflight_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight_q <= 1'b0;
      else        inflight_q <= wr_en && grace_i;
   end
endmodule

// File: rtl/nvs_pin_ctrl.sv
module nvs_pin_ctrl
   import nvs_pkg::*;
#(
   parameter int CW = 4
) (
   input  nvs_state_e    state_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] recall_first_i,
   output logic          drive_low_o,
   output logic          drive_high_o,
   output logic          store_req_o,
   output logic          recall_clear_o,
   output logic          recall_load_o
);
   assign store_req_o    = (state_i == ST_STORE);
   assign drive_low_o    = (state_i == ST_STORE) || (state_i == ST_RECALL);
   assign drive_high_o   = (state_i == ST_PULSE);
   assign recall_clear_o = (state_i == ST_RECALL) && (cnt_i == recall_first_i);
   assign recall_load_o  = (state_i == ST_RECALL) && (cnt_i == '0);
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
   import nvs_pkg::*;
#(
   parameter int DELAY_CYC  = 4,
   parameter int STORE_CYC  = 8,
   parameter int PULSE_CYC  = 2,
   parameter int LOCK_CYC   = 3,
   parameter int RECALL_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic pin_in,
   input  logic sw_store,
   input  logic sw_recall,
   input  logic rd_req,
   input  logic wr_req,
   output logic rd_en,
   output logic wr_en,
   output logic busy_drive_low,
   output logic busy_drive_high,
   output logic store_req,
   output logic recall_clear,
   output logic recall_load
);
   localparam int M1   = (DELAY_CYC > STORE_CYC) ? DELAY_CYC : STORE_CYC;
   localparam int M2   = (PULSE_CYC > LOCK_CYC) ? PULSE_CYC : LOCK_CYC;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXC = (M3 > RECALL_CYC) ? M3 : RECALL_CYC;
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CW-1:0] DLY_L = CW'(DELAY_CYC - 1);
   localparam logic [CW-1:0] STO_L = CW'(STORE_CYC - 1);
   localparam logic [CW-1:0] PUL_L = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] LCK_L = CW'(LOCK_CYC - 1);
   localparam logic [CW-1:0] RCL_L = CW'(RECALL_CYC - 1);

   generate
      if (DELAY_CYC < 1 || STORE_CYC < 1 || PULSE_CYC < 1 ||
          LOCK_CYC < 1 || RECALL_CYC < 1) begin : g_bad_len
         $error("nv_shadow_seq: every duration must be at least one cycle");
      end
   endgenerate

   nvs_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          pg_q, pg_rise, dirty_q, dirty_clr, open_w, grace_w, last_w;

   assign pg_rise   = pwr_good && !pg_q;
   assign last_w    = (cnt_q == '0);
   assign open_w    = (state_q == ST_IDLE) && pwr_good && pg_q && pin_in;
   assign grace_w   = pwr_good && ((state_q == ST_IDLE) || (state_q == ST_HWDLY));
   assign dirty_clr = last_w && ((state_q == ST_STORE) || (state_q == ST_RECALL));

   always_comb begin
      state_d = state_q;
      cnt_d   = last_w ? cnt_q : cnt_q - 1'b1;
      unique case (state_q)
         ST_IDLE: begin
            if (pg_rise) begin
               state_d = ST_RECALL; cnt_d = RCL_L;
            end else if (pg_q && !pin_in) begin
               state_d = ST_HWDLY;  cnt_d = DLY_L;
            end else if (pg_q && sw_recall) begin
               state_d = ST_RECALL; cnt_d = RCL_L;
            end else if (pg_q && sw_store && dirty_q) begin
               state_d = ST_STORE;  cnt_d = STO_L;
            end
         end
         ST_HWDLY: if (last_w) begin
            if (dirty_q || wr_en) begin
               state_d = ST_STORE; cnt_d = STO_L;
            end else begin
               state_d = ST_HOLD;
            end
         end
         ST_HOLD:   if (pin_in) state_d = ST_IDLE;
         ST_STORE:  if (last_w) begin state_d = ST_PULSE; cnt_d = PUL_L; end
         ST_PULSE:  if (last_w) begin state_d = ST_LOCK;  cnt_d = LCK_L; end
         ST_LOCK:   if (last_w) state_d = ST_IDLE;
         ST_RECALL: if (last_w) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
      if (!pwr_good) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         pg_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         pg_q    <= pwr_good;
      end
   end

   nvs_dirty_latch i_dirty (
      .clk(clk), .rst_n(rst_n), .set_i(wr_en), .clr_i(dirty_clr), .dirty_o(dirty_q)
   );

   nvs_access_gate i_gate (
      .clk(clk), .rst_n(rst_n), .open_i(open_w), .grace_i(grace_w),
      .rd_req(rd_req), .wr_req(wr_req), .rd_en(rd_en), .wr_en(wr_en)
   );

   nvs_pin_ctrl #(.CW(CW)) i_pin (
      .state_i(state_q), .cnt_i(cnt_q), .recall_first_i(RCL_L),
      .drive_low_o(busy_drive_low), .drive_high_o(busy_drive_high),
      .store_req_o(store_req), .recall_clear_o(recall_clear),
      .recall_load_o(recall_load)
   );
endmodule

// File: rtl/nv_shadow_seq_chk.sv
module nv_shadow_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_good,
   input logic rd_en,
   input logic wr_en,
   input logic busy_drive_low,
   input logic busy_drive_high,
   input logic store_req,
   input logic recall_clear,
   input logic recall_load
);
   assert_drive_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_drive_low && busy_drive_high));

   assert_no_access_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_drive_low |-> (!rd_en && !wr_en));

   assert_pulse_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(store_req) && $past(pwr_good)) |-> busy_drive_high);

   assert_lock_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_drive_high) |-> (!rd_en && !wr_en));

   assert_recall_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (recall_clear || recall_load) |-> (busy_drive_low && !store_req));

   assert_power_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> (!rd_en && !wr_en));
endmodule

bind nv_shadow_seq nv_shadow_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .rd_en(rd_en), .wr_en(wr_en),
   .busy_drive_low(busy_drive_low), .busy_drive_high(busy_drive_high),
   .store_req(store_req), .recall_clear(recall_clear), .recall_load(recall_load)
);

// File: tb/test_nv_shadow_seq.sv
module test_nv_shadow_seq;
   localparam int DLY = 4, STO = 8, PUL = 2, LCK = 3, RCL = 6;

   logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, ext_n = 1'b1;
   logic sw_store = 1'b0, sw_recall = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
   logic rd_en, wr_en, busy_drive_low, busy_drive_high, store_req, recall_clear, recall_load;
   logic pin;
   int compared = 0, mismatched = 0;

   always #4 clk = ~clk;
   assign pin = busy_drive_low ? 1'b0 : (busy_drive_high ? 1'b1 : ext_n);

   nv_shadow_seq #(.DELAY_CYC(DLY), .STORE_CYC(STO), .PULSE_CYC(PUL),
                   .LOCK_CYC(LCK), .RECALL_CYC(RCL)) i_nv_shadow_seq (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pin_in(pin),
      .sw_store(sw_store), .sw_recall(sw_recall), .rd_req(rd_req), .wr_req(wr_req),
      .rd_en(rd_en), .wr_en(wr_en), .busy_drive_low(busy_drive_low),
      .busy_drive_high(busy_drive_high), .store_req(store_req),
      .recall_clear(recall_clear), .recall_load(recall_load));

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // advance to the next falling edge, then settle
   task automatic step();
      @(negedge clk); #1;
   endtask

   // measure a store: cycles of drive-low (with store_req), pulse, lockout
   task automatic measure_store(output int lo, output int sr, output int hi, output int lk);
      lo = 0; sr = 0; hi = 0; lk = 0;
      for (int i = 0; i < 200 && !busy_drive_low; i++) step();
      while (busy_drive_low && lo < 200) begin
         lo++; if (store_req) sr++; step();
      end
      while (busy_drive_high && hi < 200) begin hi++; step(); end
      while (!rd_en && lk < 200) begin lk++; step(); end
   endtask

   task automatic measure_recall(output int lo, output int nclr, output int nld, output int hi);
      lo = 0; nclr = 0; nld = 0; hi = 0;
      for (int i = 0; i < 200 && !busy_drive_low; i++) step();
      while (busy_drive_low && lo < 200) begin
         lo++; nclr += int'(recall_clear); nld += int'(recall_load);
         if (store_req) hi += 100;
         step();
      end
      if (busy_drive_high) hi++;
   endtask

   task automatic write_once();
      wr_req = 1'b1; step(); chk("R2 write grant", int'(wr_en), 1);
      wr_req = 1'b0; step();
   endtask

   task automatic pulse_sw(input bit store);
      if (store) sw_store = 1'b1; else sw_recall = 1'b1;
      step(); sw_store = 1'b0; sw_recall = 1'b0;
   endtask

   int a, b, c, d, seen;

   initial begin : watchdog
      #1_000_000;
      mismatched++; compared++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #1;
      chk("reset rd_en", int'(rd_en), 0);
      chk("reset busy_drive_low", int'(busy_drive_low), 0);
      chk("reset store_req", int'(store_req), 0);
      step(); step();
      rd_req = 1'b1;
      rst_n = 1'b1;
      // R8/R9: power already good at reset release -> automatic recall
      measure_recall(a, b, c, d);
      chk("R8 power-up recall length", a, RCL);
      chk("R9 clear strobes", b, 1);
      chk("R9 load strobes", c, 1);
      chk("R8 no pulse after recall", d, 0);
      chk("R8 access after recall", int'(rd_en), 1);

      // R2: software store with clean latch is ignored
      pulse_sw(1'b1);
      seen = 0;
      for (int i = 0; i < 20; i++) begin seen += int'(busy_drive_low); step(); end
      chk("R2 clean sw store ignored", seen, 0);

      // R5/R6/R7: software store after a write
      write_once();
      pulse_sw(1'b1);
      measure_store(a, b, c, d);
      chk("R5 store drive-low length", a, STO);
      chk("R5 store_req length", b, STO);
      chk("R6 drive-high pulse length", c, PUL);
      chk("R7 lockout length", d, LCK);
      // R2: store cleared the latch
      pulse_sw(1'b1);
      seen = 0;
      for (int i = 0; i < 20; i++) begin seen += int'(busy_drive_low); step(); end
      chk("R2 latch cleared by store", seen, 0);

      // R4: clean pin request blocks access but never drives busy
      ext_n = 1'b0;
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         step(); seen += int'(busy_drive_low) + int'(rd_en);
      end
      chk("R4 clean request blocks, no busy", seen, 0);
      ext_n = 1'b1; step();
      chk("R4 access after release", int'(rd_en), 1);

      // R1: pin request with dirty latch: delay then store
      write_once();
      ext_n = 1'b0;
      a = 0;
      step();
      while (!busy_drive_low && a < 100) begin a++; step(); end
      chk("R1 delay before store", a, DLY);
      measure_store(a, b, c, d);
      chk("R5 hw store length", a, STO);
      chk("R6 hw pulse length", c, PUL);
      // line still held low: held in clean request until release
      chk("R4 held while pin low", int'(rd_en), 0);
      ext_n = 1'b1; step();
      chk("R4 released", int'(rd_en), 1);

      // R3: in-flight write survives delay window
      rd_req = 1'b0;
      wr_req = 1'b1; step();
      chk("R3 write granted before request", int'(wr_en), 1);
      ext_n = 1'b0; step();
      chk("R3 in-flight write continues", int'(wr_en), 1);
      step();
      chk("R3 in-flight write in window", int'(wr_en), 1);
      wr_req = 1'b0; step();
      wr_req = 1'b1; #1;
      chk("R3 new write refused", int'(wr_en), 0);
      wr_req = 1'b0;
      rd_req = 1'b1;
      measure_store(a, b, c, d);
      chk("R1 store from in-flight dirty", a, STO);
      ext_n = 1'b1; step();

      // R3: write requested after pin low with clean latch is refused
      ext_n = 1'b0; step();
      wr_req = 1'b1;
      seen = 0;
      for (int i = 0; i < 15; i++) begin
         step(); seen += int'(wr_en) + int'(busy_drive_low);
      end
      chk("R3 late write blocked", seen, 0);
      ext_n = 1'b1; step();
      chk("R3 write after release", int'(wr_en), 1);
      wr_req = 1'b0; step();

      // R8/R9/R2: software recall clears dirty latch
      pulse_sw(1'b0);
      measure_recall(a, b, c, d);
      chk("R8 sw recall length", a, RCL);
      chk("R9 sw recall strobes", b + c, 2);
      chk("R8 no pulse after sw recall", d, 0);
      pulse_sw(1'b1);
      seen = 0;
      for (int i = 0; i < 20; i++) begin seen += int'(busy_drive_low); step(); end
      chk("R2 latch cleared by recall", seen, 0);

      // R10: power loss blocks access; return triggers recall
      pwr_good = 1'b0; wr_req = 1'b1;
      seen = 0;
      for (int i = 0; i < 5; i++) begin step(); seen += int'(rd_en) + int'(wr_en); end
      chk("R10 no access without power", seen, 0);
      wr_req = 1'b0;
      pwr_good = 1'b1;
      measure_recall(a, b, c, d);
      chk("R8 recall on power return", a, RCL);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule